// File: doc/BRIEF.md
# Host Bus Interrupt and Configuration Registers

This block is a 32-bit register file on a peripheral bus. It gathers interrupt events from a low-speed host bus controller into sticky status bits: the serial interrupt lines, a link-reset event, the cycle synchronisation errors and the bus-master requests. It also keeps the controller's configuration words: a firmware segment select, a firmware read burst size, and the serial-interrupt control settings. The logic that drives the serial-interrupt waveform sits elsewhere. This block only holds the values that program it.

There are two interrupt groups. The controller group has a sticky status word and a mask. The masked OR of that group forms the controller interrupt, which feeds bit 11 of a second, bus-master group. The bus-master group has a status word, a mask, a per-bit polarity and a read-only view of its live inputs. The masked OR of the master status drives the single interrupt output. Software reads and writes whole 32-bit words at byte offsets that are multiples of four. Reads have no side effects.

Top module: `hostbus_irq_regs`

## Requirements
- R1: After reset the read-size register reads 0x02000000 (4-byte encoding) and every other mapped register reads 0. The interrupt output is low.
- R2: A controller event held high at a clock edge sets its status bit (offset 0x38) at that edge, and the bit stays set. Only bits 31:15, 10 and 7:0 exist. Events on bits 14:11 and 9:8 are ignored and those bits read 0.
- R3: Writing status (0x38 or 0x50) clears every bit written as one and leaves the bits written as zero unchanged.
- R4: When a set condition and a clear write hit the same status bit at the same edge, the bit ends up set.
- R5: Master input bit 11 is the controller interrupt, which is the OR of (controller status AND controller mask). Bit 11 of the external master lines is ignored.
- R6: A master status bit (0x50) is set at an edge where its input XOR its polarity bit (0x58) is one.
- R7: The interrupt output is high exactly when (master status AND master mask at 0x54) is nonzero.
- R8: Offset 0x5C reads the live master inputs before polarity is applied, with bit 11 taken from the controller interrupt. Writes to 0x5C change nothing.
- R9: Serial-interrupt control (0x30) keeps only bit 31 (enable), bit 30 (quiet mode) and bits 25:24 (start-frame length: 0 = 4, 1 = 6, 2 = 8 clocks). All other bits read 0.
- R10: Read size (0x28) keeps only bits 26:24, with encodings 0x0 1 B, 0x1 2 B, 0x2 4 B, 0x4 16 B and 0x7 128 B. All other bits read 0.
- R11: The firmware segment select (0x24) stores and returns all 32 bits.
- R12: The error-address register (0x40) reads 0 and ignores writes.
- R13: A read from an unmapped offset, or from an offset whose two low bits are nonzero, returns 0xFFFFFFFF. A write there changes no register.
- R14: The controller mask (0x34) stores only the bits that exist in controller status. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| hc_events | input | 32 | Controller event lines, active high, one per status bit |
| mst_lines | input | 32 | Raw bus-master interrupt lines (bit 11 unused) |
| irq_out | output | 1 | Masked master interrupt |

## Verification
A dropped or stuck status bit shows up at the status offset one edge after the event, and at `irq_out` at once when that bit is unmasked. The controller-to-master chain adds one more edge, so an error in the bit-11 routing shows up two edges after the event, both in master status and on the output. A wrong clear or a wrong set-versus-clear priority leaves a status word that differs from the expected word at the very next read. Configuration field pruning and unmapped decoding show up on the first read after the write.

// File: rtl/hbirq_pkg.sv
package hbirq_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned HC_IRQ_BIT = 11;

    localparam logic [7:0] OFF_FWSEG  = 8'h24;
    localparam logic [7:0] OFF_RDSIZE = 8'h28;
    localparam logic [7:0] OFF_SIRQ   = 8'h30;
    localparam logic [7:0] OFF_HCMASK = 8'h34;
    localparam logic [7:0] OFF_HCSTAT = 8'h38;
    localparam logic [7:0] OFF_ERRADR = 8'h40;
    localparam logic [7:0] OFF_MSTAT  = 8'h50;
    localparam logic [7:0] OFF_MMASK  = 8'h54;
    localparam logic [7:0] OFF_MPOL   = 8'h58;
    localparam logic [7:0] OFF_MLIVE  = 8'h5C;

    // serial lines 31:15, link reset 10, sync errors / master bits 7:0
    localparam logic [DATA_W-1:0] HC_IMPL  = 32'hFFFF_84FF;
    localparam logic [DATA_W-1:0] MST_IMPL = '1;
    localparam logic [2:0]        RDSIZE_RST = 3'd2;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_FWSEG, SEL_RDSIZE, SEL_SIRQ, SEL_HCMASK, SEL_HCSTAT,
        SEL_ERRADR, SEL_MSTAT, SEL_MMASK, SEL_MPOL, SEL_MLIVE
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] seg;
        logic [2:0]        rdsize;
        logic              sirq_en;
        logic              sirq_quiet;
        logic [1:0]        sirq_start;
    } cfg_t;

    function automatic reg_sel_e decode_off(input logic [7:0] off);
        reg_sel_e s;
        case (off)
            OFF_FWSEG:  s = SEL_FWSEG;
            OFF_RDSIZE: s = SEL_RDSIZE;
            OFF_SIRQ:   s = SEL_SIRQ;
            OFF_HCMASK: s = SEL_HCMASK;
            OFF_HCSTAT: s = SEL_HCSTAT;
            OFF_ERRADR: s = SEL_ERRADR;
            OFF_MSTAT:  s = SEL_MSTAT;
            OFF_MMASK:  s = SEL_MMASK;
            OFF_MPOL:   s = SEL_MPOL;
            OFF_MLIVE:  s = SEL_MLIVE;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] pack_rdsize(input cfg_t c);
        return {5'd0, c.rdsize, 24'd0};
    endfunction

    function automatic logic [DATA_W-1:0] pack_sirq(input cfg_t c);
        return {c.sirq_en, c.sirq_quiet, 4'd0, c.sirq_start, 24'd0};
    endfunction

endpackage

// File: rtl/hbirq_bank.sv
module hbirq_bank
    import hbirq_pkg::*;
#(
    parameter int unsigned      W    = 32,
    parameter logic [W-1:0]     IMPL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lines,
    input  logic [W-1:0] pol,
    input  logic         we_stat,
    input  logic         we_mask,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stat,
    output logic [W-1:0] mask,
    output logic         irq
);

    logic [W-1:0] set_vec, clr_vec, stat_d;

    always_comb begin
        set_vec = (lines ^ pol) & IMPL;
        clr_vec = we_stat ? wdata : '0;
        stat_d  = ((stat & ~clr_vec) | set_vec) & IMPL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            mask <= '0;
        end else begin
            stat <= stat_d;
            if (we_mask) mask <= wdata & IMPL;
        end
    end

    assign irq = |(stat & mask);

    // R4: a pending set beats a clear at the same edge
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((stat & $past(set_vec)) == $past(set_vec)));

    // R3: bits written as one are gone unless re-set
    assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
        we_stat |=> ((stat & $past(wdata & ~set_vec)) == '0));

    // R2: with no write, set bits stay set
    assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        !we_stat |=> ((stat & $past(stat)) == $past(stat)));

endmodule

// File: rtl/hbirq_cfg.sv
module hbirq_cfg
    import hbirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_seg,
    input  logic              we_rdsize,
    input  logic              we_sirq,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg        <= '0;
            cfg.rdsize <= RDSIZE_RST;
        end else begin
            if (we_seg)    cfg.seg    <= wdata;
            if (we_rdsize) cfg.rdsize <= wdata[26:24];
            if (we_sirq) begin
                cfg.sirq_en    <= wdata[31];
                cfg.sirq_quiet <= wdata[30];
                cfg.sirq_start <= wdata[25:24];
            end
        end
    end

    // R1: read size comes out of reset at the 4-byte encoding
    assert_rdsize_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cfg.rdsize == RDSIZE_RST));

endmodule

// File: rtl/hostbus_irq_regs.sv
module hostbus_irq_regs
    import hbirq_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] hc_events,
    input  logic [DATA_W-1:0] mst_lines,
    output logic              irq_out
);

    logic     hi_zero;
    reg_sel_e sel;
    cfg_t     cfg;

    generate
        if (ADDR_W > 8) begin : g_hi
            assign hi_zero = ~|addr[ADDR_W-1:8];
        end else begin : g_nohi
            assign hi_zero = 1'b1;
        end
    endgenerate

    assign sel = (hi_zero && addr[1:0] == 2'b00) ? decode_off(addr[7:0]) : SEL_NONE;

    logic [DATA_W-1:0] hc_stat, hc_mask, mst_stat, mst_mask, mst_pol, mst_live;
    logic              hc_irq;

    hbirq_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .we_seg    (wr_en && sel == SEL_FWSEG),
        .we_rdsize (wr_en && sel == SEL_RDSIZE),
        .we_sirq   (wr_en && sel == SEL_SIRQ),
        .wdata     (wdata),
        .cfg       (cfg)
    );

    hbirq_bank #(.W(DATA_W), .IMPL(HC_IMPL)) u_hc (
        .clk     (clk),
        .rst     (rst),
        .lines   (hc_events),
        .pol     ('0),
        .we_stat (wr_en && sel == SEL_HCSTAT),
        .we_mask (wr_en && sel == SEL_HCMASK),
        .wdata   (wdata),
        .stat    (hc_stat),
        .mask    (hc_mask),
        .irq     (hc_irq)
    );

    always_ff @(posedge clk) begin
        if (rst)                          mst_pol <= '0;
        else if (wr_en && sel == SEL_MPOL) mst_pol <= wdata;
    end

    always_comb begin
        mst_live             = mst_lines;
        mst_live[HC_IRQ_BIT] = hc_irq;
    end

    hbirq_bank #(.W(DATA_W), .IMPL(MST_IMPL)) u_mst (
        .clk     (clk),
        .rst     (rst),
        .lines   (mst_live),
        .pol     (mst_pol),
        .we_stat (wr_en && sel == SEL_MSTAT),
        .we_mask (wr_en && sel == SEL_MMASK),
        .wdata   (wdata),
        .stat    (mst_stat),
        .mask    (mst_mask),
        .irq     (irq_out)
    );

    always_comb begin
        unique case (sel)
            SEL_FWSEG:  rdata = cfg.seg;
            SEL_RDSIZE: rdata = pack_rdsize(cfg);
            SEL_SIRQ:   rdata = pack_sirq(cfg);
            SEL_HCMASK: rdata = hc_mask;
            SEL_HCSTAT: rdata = hc_stat;
            SEL_ERRADR: rdata = '0;
            SEL_MSTAT:  rdata = mst_stat;
            SEL_MMASK:  rdata = mst_mask;
            SEL_MPOL:   rdata = mst_pol;
            SEL_MLIVE:  rdata = mst_live;
            default:    rdata = '1;
        endcase
    end

    // R5: a raised controller interrupt lands in master bit 11 next edge
    assert_hc_route_R5: assert property (@(posedge clk) disable iff (rst)
        hc_irq |=> mst_stat[HC_IRQ_BIT]);

    // R7: nothing can raise the output while the master mask is clear
    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (rst)
        (mst_mask == '0) |-> !irq_out);

endmodule

// File: tb/hostbus_irq_regs_tb.sv
module hostbus_irq_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] hc_events = '0;
    logic [31:0] mst_lines = '0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hostbus_irq_regs dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .hc_events(hc_events), .mst_lines(mst_lines), .irq_out(irq_out)
    );

    localparam int NV = 12;
    localparam logic [11:0] V_ADDR [NV] = '{
        12'h024, 12'h028, 12'h028, 12'h030, 12'h030, 12'h034,
        12'h040, 12'h054, 12'h058, 12'h05C, 12'h044, 12'h026};
    localparam logic [31:0] V_WR [NV] = '{
        32'hDEADBEEF, 32'hFFFFFFFF, 32'h04000000, 32'hFFFFFFFF, 32'h81000000, 32'hFFFFFFFF,
        32'h12345678, 32'hA5A5A5A5, 32'h0000F00F, 32'hFFFFFFFF, 32'h00000001, 32'h00000001};
    localparam logic [31:0] V_EXP [NV] = '{
        32'hDEADBEEF, 32'h07000000, 32'h04000000, 32'hC3000000, 32'h81000000, 32'hFFFF84FF,
        32'h00000000, 32'hA5A5A5A5, 32'h0000F00F, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF};
    localparam string V_TAG [NV] = '{
        "R11", "R10", "R10", "R9", "R9", "R14", "R12", "R7", "R6", "R8", "R13", "R13"};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic hc_pulse(input logic [31:0] v);
        @(negedge clk);
        hc_events = v;
        @(negedge clk);
        hc_events = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd("R1 fwseg", 12'h024, 32'h0);
        rd("R1 rdsize", 12'h028, 32'h02000000);
        rd("R1 sirq", 12'h030, 32'h0);
        rd("R1 hcmask", 12'h034, 32'h0);
        rd("R1 hcstat", 12'h038, 32'h0);
        rd("R1 mstat", 12'h050, 32'h0);
        rd("R1 mpol", 12'h058, 32'h0);
        chk("R1 irq_out", {31'd0, irq_out}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            wr(V_ADDR[i], V_WR[i]);
            rd(V_TAG[i], V_ADDR[i], V_EXP[i]);
        end

        // cleanup after polarity row
        wr(12'h058, 32'h0);
        wr(12'h054, 32'h0);
        wr(12'h050, 32'hFFFFFFFF);
        rd("R3 mstat cleared", 12'h050, 32'h0);
        chk("R7 irq low", {31'd0, irq_out}, 32'h0);

        // R13 misaligned write dropped
        rd("R13 seg kept", 12'h024, 32'hDEADBEEF);
        rd("R13 hole read", 12'h02C, 32'hFFFFFFFF);
        rd("R13 high addr", 12'h124, 32'hFFFFFFFF);

        // R2 sticky set and layout
        wr(12'h034, 32'h0);
        hc_pulse(32'hFFFFFFFF);
        @(negedge clk);
        rd("R2 layout", 12'h038, 32'hFFFF84FF);
        rd("R5 masked hc", 12'h050, 32'h0);

        // R3 partial clear
        wr(12'h038, 32'h0000FF00);
        rd("R3 partial", 12'h038, 32'hFFFF00FF);
        wr(12'h038, 32'hFFFFFFFF);
        rd("R3 all", 12'h038, 32'h0);

        // R4 set beats clear
        @(negedge clk);
        hc_events = 32'h1; addr = 12'h038; wdata = 32'h1; wr_en = 1'b1;
        @(negedge clk);
        hc_events = '0; wr_en = 1'b0;
        rd("R4 set wins", 12'h038, 32'h1);
        wr(12'h038, 32'h1);
        rd("R4 then clear", 12'h038, 32'h0);

        // R5 / R7 chain
        wr(12'h034, 32'h400);
        wr(12'h054, 32'h800);
        hc_pulse(32'h400);
        @(negedge clk);
        rd("R5 chained", 12'h050, 32'h800);
        chk("R7 irq high", {31'd0, irq_out}, 32'h1);
        rd("R8 live bit11", 12'h05C, 32'h800);
        wr(12'h038, 32'h400);
        rd("R2 master sticky", 12'h050, 32'h800);
        chk("R7 irq held", {31'd0, irq_out}, 32'h1);
        wr(12'h050, 32'h800);
        rd("R3 mstat clear", 12'h050, 32'h0);
        chk("R7 irq dropped", {31'd0, irq_out}, 32'h0);
        mst_lines = 32'h800;
        repeat (2) @(negedge clk);
        rd("R5 line11 ignored", 12'h050, 32'h0);
        rd("R8 live ignores line11", 12'h05C, 32'h0);
        mst_lines = '0;

        // R7 mask gating
        wr(12'h054, 32'h0);
        @(negedge clk); mst_lines = 32'h1;
        @(negedge clk); mst_lines = '0;
        rd("R6 line set", 12'h050, 32'h1);
        chk("R7 masked off", {31'd0, irq_out}, 32'h0);
        wr(12'h054, 32'h1);
        chk("R7 unmasked", {31'd0, irq_out}, 32'h1);
        wr(12'h050, 32'h1);
        chk("R7 cleared", {31'd0, irq_out}, 32'h0);

        // R6 polarity, R8 read-only live
        wr(12'h058, 32'h10);
        @(negedge clk);
        rd("R6 inverted set", 12'h050, 32'h10);
        mst_lines = 32'h10;
        wr(12'h050, 32'h10);
        rd("R6 no set when line high", 12'h050, 32'h0);
        rd("R8 raw live", 12'h05C, 32'h10);
        wr(12'h05C, 32'h0);
        rd("R8 write ignored", 12'h05C, 32'h10);
        rd("R8 no status change", 12'h050, 32'h0);
        mst_lines = '0;
        wr(12'h058, 32'h0);
        wr(12'h050, 32'hFFFFFFFF);
        rd("R6 restored", 12'h050, 32'h0);

        // R1 reset again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd("R1 seg after reset", 12'h024, 32'h0);
        rd("R1 rdsize after reset", 12'h028, 32'h02000000);
        rd("R1 mpol after reset", 12'h058, 32'h0);

        finish_run();
    end

endmodule